// File: doc/BRIEF.md
# Looped-Back Byte Channel Pattern Engine

This block exercises one byte-wide channel end to end. Its generator side sends a repeating block: a down-counter walks from 200 to 1, each value is sent with bit 4 forced to zero, and a fixed marker byte closes the block. Because the marker has bit 4 set, no data byte can be mistaken for it. The generator waits on a ready handshake and keeps its place while held.

The checker side takes the byte stream after it has passed through the channel under test. It first hunts for a marker. Once it is locked, it predicts every data byte, counts mismatches, flags blocks that run past the end of the count, and checks each block's length when the next marker arrives. At every marker it publishes a report: a three-bit error class, the expected value it had reached, and the mismatch count for the block. A saturating counter totals the blocks that had any error, and a sticky flag shows that at least one did. A start pulse restarts the generator and clears all checker state.

Top module: `loop_pattern_engine`

## Requirements
- R1: After a start pulse the generator sends, for each block, the byte values 200 down to 1 each ANDed with 0xEF, then the marker 0x3E. That makes 201 bytes per block, and blocks repeat without a gap while ready stays high.
- R2: While tx_valid_o is high and tx_ready_i is low, tx_data_o holds its value and tx_valid_o stays high. The byte that was held is the next one sent once ready returns, so no byte is skipped.
- R3: After reset tx_valid_o is low until the first start pulse. A start pulse restarts the sequence at 200, clears err_cnt_o and err_flag_o, and returns the checker to marker hunting.
- R4: A received byte counts as a marker when its low six bits equal 0x3E, whatever its two upper bits are.
- R5: Until the first marker after reset or start, received bytes raise no report and record no error. The first marker only locks the checker and produces no report.
- R6: While the expected value is not zero, a data byte is compared with the expected value under mask 0xEF. A difference sets class bit 0 (mismatch) and adds one to the block's mismatch count, which saturates. A difference in bit 4 alone is not a mismatch.
- R7: A data byte that arrives when the expected value is already zero sets class bit 1 (overlong). That byte is not compared, and it does not change the mismatch count.
- R8: When a locked marker arrives and the block did not hold exactly 200 data bytes (201 bytes including the marker), class bit 2 (bad length) is set in that block's report.
- R9: The cycle after a locked marker is accepted, rep_valid_o is high for one cycle with the class, the expected value at marker time, and the mismatch count. The checker then clears its errors and mismatch count and reloads the expected value to 200 for the next block.
- R10: err_cnt_o goes up by one in the cycle after a report whose class is not zero. It stops at its maximum value and does not wrap.
- R11: err_flag_o is set together with the first increment of err_cnt_o. It stays high until a start pulse or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Restart generator and clear the checker |
| tx_data_o | output | 8 | Generated byte |
| tx_valid_o | output | 1 | Generated byte is valid |
| tx_ready_i | input | 1 | Channel accepts the generated byte |
| rx_data_i | input | 8 | Looped-back byte |
| rx_valid_i | input | 1 | Looped-back byte strobe |
| rep_valid_o | output | 1 | Block report strobe |
| rep_class_o | output | 3 | Error class: bit0 mismatch, bit1 overlong, bit2 bad length |
| rep_last_o | output | 8 | Expected value reached when the marker arrived |
| rep_mism_o | output | MISM_W (8) | Mismatching bytes in the block |
| err_flag_o | output | 1 | Sticky: some block had an error |
| err_cnt_o | output | ERRCNT_W (4) | Saturating count of blocks with an error |

## Verification
Some properties are checked on every cycle. The generator holds its byte under back-pressure, and it never sends a byte that looks like a marker unless the byte is the marker itself. Reports appear only right after an accepted byte, and a nonzero mismatch count always comes with class bit 0. The errored-block count never goes down without a start pulse, and whenever it is nonzero the flag is set. Other behaviour only the directed scenarios can show: the exact byte sequence and block length, hunting before lock, the masked compare, the overlong and short-block classes, the reload after each report, and the count stopping at its maximum.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    localparam int BYTE_W = 8;
    localparam int MISM_W = 8;

    // error class, bit order is visible on rep_class_o
    typedef struct packed {
        logic bad_len;   // bit 2
        logic overlong;  // bit 1
        logic mism;      // bit 0
    } err_cls_t;

    typedef struct packed {
        err_cls_t             cls;
        logic [BYTE_W-1:0]    last;
        logic [MISM_W-1:0]    mism;
    } blk_rpt_t;

    function automatic logic is_marker(input logic [BYTE_W-1:0] b,
                                       input logic [BYTE_W-1:0] mk);
        return b[5:0] == mk[5:0];
    endfunction

    function automatic logic [BYTE_W-1:0] mask_byte(input logic [BYTE_W-1:0] b,
                                                     input logic [BYTE_W-1:0] m);
        return b & m;
    endfunction

endpackage

// File: rtl/lpe_gen.sv
module lpe_gen
    import lpe_pkg::*;
#(
    parameter int               START_VAL = 200,
    parameter logic [BYTE_W-1:0] MARKER    = 8'h3E,
    parameter logic [BYTE_W-1:0] DATA_MASK = 8'hEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ready,
    output logic              valid,
    output logic [BYTE_W-1:0] data
);
    localparam logic [BYTE_W-1:0] RELOAD = BYTE_W'(START_VAL);

    logic              running;
    logic [BYTE_W-1:0] ctr;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            ctr     <= RELOAD;
        end else if (start) begin
            running <= 1'b1;
            ctr     <= RELOAD;
        end else if (running && ready) begin
            ctr <= (ctr == '0) ? RELOAD : ctr - 1'b1;
        end
    end

    assign valid = running;
    assign data  = (ctr == '0) ? MARKER : mask_byte(ctr, DATA_MASK);

endmodule

// File: rtl/lpe_chk.sv
module lpe_chk
    import lpe_pkg::*;
#(
    parameter int               START_VAL = 200,
    parameter logic [BYTE_W-1:0] MARKER    = 8'h3E,
    parameter logic [BYTE_W-1:0] DATA_MASK = 8'hEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rpt_valid,
    output blk_rpt_t          rpt
);
    localparam int                LEN_W  = $clog2(START_VAL + 2) + 1;
    localparam logic [BYTE_W-1:0] RELOAD = BYTE_W'(START_VAL);
    localparam logic [LEN_W-1:0]  GOOD_N = LEN_W'(START_VAL);

    logic              locked;
    logic [BYTE_W-1:0] exp_q;
    logic [LEN_W-1:0]  len_q;
    logic [MISM_W-1:0] mism_q;
    err_cls_t          cls_q;

    logic     mark;
    logic     differs;
    err_cls_t cls_final;

    always_comb begin
        mark      = is_marker(rx_data, MARKER);
        differs   = mask_byte(rx_data, DATA_MASK) != mask_byte(exp_q, DATA_MASK);
        cls_final = cls_q;
        if (len_q != GOOD_N) cls_final.bad_len = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            locked    <= 1'b0;
            exp_q     <= RELOAD;
            len_q     <= '0;
            mism_q    <= '0;
            cls_q     <= '0;
            rpt_valid <= 1'b0;
            rpt       <= '0;
        end else begin
            rpt_valid <= 1'b0;
            if (rx_valid) begin
                if (mark) begin
                    if (locked) begin
                        rpt_valid <= 1'b1;
                        rpt.cls   <= cls_final;
                        rpt.last  <= exp_q;
                        rpt.mism  <= mism_q;
                    end
                    locked <= 1'b1;
                    exp_q  <= RELOAD;
                    len_q  <= '0;
                    mism_q <= '0;
                    cls_q  <= '0;
                end else if (locked) begin
                    if (!(&len_q)) len_q <= len_q + 1'b1;
                    if (exp_q == '0) begin
                        cls_q.overlong <= 1'b1;
                    end else begin
                        if (differs) begin
                            cls_q.mism <= 1'b1;
                            if (!(&mism_q)) mism_q <= mism_q + 1'b1;
                        end
                        exp_q <= exp_q - 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lpe_errcnt.sv
module lpe_errcnt #(
    parameter int ERRCNT_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                inc,
    output logic [ERRCNT_W-1:0] cnt,
    output logic                flag
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (inc) begin
            flag <= 1'b1;
            if (!(&cnt)) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/loop_pattern_engine.sv
module loop_pattern_engine
    import lpe_pkg::*;
#(
    parameter int               START_VAL = 200,
    parameter logic [BYTE_W-1:0] MARKER    = 8'h3E,
    parameter logic [BYTE_W-1:0] DATA_MASK = 8'hEF,
    parameter int               ERRCNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    output logic [BYTE_W-1:0]   tx_data_o,
    output logic                tx_valid_o,
    input  logic                tx_ready_i,
    input  logic [BYTE_W-1:0]   rx_data_i,
    input  logic                rx_valid_i,
    output logic                rep_valid_o,
    output logic [2:0]          rep_class_o,
    output logic [BYTE_W-1:0]   rep_last_o,
    output logic [MISM_W-1:0]   rep_mism_o,
    output logic                err_flag_o,
    output logic [ERRCNT_W-1:0] err_cnt_o
);
    blk_rpt_t rpt;
    logic     rpt_valid;

    lpe_gen #(.START_VAL(START_VAL), .MARKER(MARKER), .DATA_MASK(DATA_MASK)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .ready (tx_ready_i),
        .valid (tx_valid_o),
        .data  (tx_data_o)
    );

    lpe_chk #(.START_VAL(START_VAL), .MARKER(MARKER), .DATA_MASK(DATA_MASK)) u_chk (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .rx_valid  (rx_valid_i),
        .rx_data   (rx_data_i),
        .rpt_valid (rpt_valid),
        .rpt       (rpt)
    );

    lpe_errcnt #(.ERRCNT_W(ERRCNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_i),
        .inc  (rpt_valid && (rpt.cls != '0)),
        .cnt  (err_cnt_o),
        .flag (err_flag_o)
    );

    assign rep_valid_o = rpt_valid;
    assign rep_class_o = rpt.cls;
    assign rep_last_o  = rpt.last;
    assign rep_mism_o  = rpt.mism;

endmodule

// File: rtl/lpe_sva.sv
module lpe_sva #(
    parameter int         ERRCNT_W = 4,
    parameter logic [7:0] MARKER   = 8'h3E
) (
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [7:0]          tx_data_o,
    input logic                tx_valid_o,
    input logic                tx_ready_i,
    input logic                rx_valid_i,
    input logic                rep_valid_o,
    input logic [2:0]          rep_class_o,
    input logic [7:0]          rep_mism_o,
    input logic                err_flag_o,
    input logic [ERRCNT_W-1:0] err_cnt_o
);
    assert_hold_under_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i && !start_i) |=> (tx_valid_o && $stable(tx_data_o)));

    assert_no_false_marker_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && tx_data_o[5:0] == MARKER[5:0]) |-> (tx_data_o == MARKER));

    assert_report_follows_byte_R9: assert property (@(posedge clk) disable iff (rst)
        rep_valid_o |-> $past(rx_valid_i));

    assert_mism_sets_class_R6: assert property (@(posedge clk) disable iff (rst)
        (rep_valid_o && rep_mism_o != 8'd0) |-> rep_class_o[0]);

    assert_count_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (err_cnt_o >= $past(err_cnt_o)));

    assert_flag_with_count_R11: assert property (@(posedge clk) disable iff (rst)
        (err_cnt_o != '0) |-> err_flag_o);
endmodule

bind loop_pattern_engine lpe_sva #(.ERRCNT_W(ERRCNT_W), .MARKER(MARKER)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .rx_valid_i  (rx_valid_i),
    .rep_valid_o (rep_valid_o),
    .rep_class_o (rep_class_o),
    .rep_mism_o  (rep_mism_o),
    .err_flag_o  (err_flag_o),
    .err_cnt_o   (err_cnt_o)
);

// File: tb/loop_pattern_engine_test.sv
module loop_pattern_engine_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] tx_data_o;
    logic       tx_valid_o;
    logic       tx_ready_i = 1'b0;
    logic [7:0] rx_data_i;
    logic       rx_valid_i;
    logic       rep_valid_o;
    logic [2:0] rep_class_o;
    logic [7:0] rep_last_o;
    logic [7:0] rep_mism_o;
    logic       err_flag_o;
    logic [3:0] err_cnt_o;

    logic       loop_sel = 1'b0;
    logic [7:0] drv_data = 8'h00;
    logic       drv_valid = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    assign rx_valid_i = loop_sel ? (tx_valid_o && tx_ready_i) : drv_valid;
    assign rx_data_i  = loop_sel ? tx_data_o : drv_data;

    always #2.5 clk = ~clk;

    loop_pattern_engine uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i),
        .rep_valid_o(rep_valid_o), .rep_class_o(rep_class_o),
        .rep_last_o(rep_last_o), .rep_mism_o(rep_mism_o),
        .err_flag_o(err_flag_o), .err_cnt_o(err_cnt_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int idx);
        int k = idx % 201;
        if (k == 200) return 8'h3E;
        return 8'(200 - k) & 8'hEF;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        drv_data = b; drv_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle();
        drv_valid = 1'b0;
        @(negedge clk);
    endtask

    // n data bytes (expected 200 downward, 0x00 past the end), optional corruptions, then marker
    task automatic send_block(input int n, input int bad_a, input int bad_b, input int flip4,
                              input logic [7:0] mk);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = (200 - k >= 1) ? (8'(200 - k) & 8'hEF) : 8'h00;
            if (k == bad_a || k == bad_b) v = v ^ 8'h01;
            if (k == flip4) v = v ^ 8'h10;
            send_byte(v);
            check(!rep_valid_o, "R9 no report mid-block", rep_valid_o, 0);
        end
        send_byte(mk);
    endtask

    task automatic t_reset();
        check(tx_valid_o == 1'b0, "R3 tx idle after reset", tx_valid_o, 0);
        check(rep_valid_o == 1'b0, "R9 no report after reset", rep_valid_o, 0);
        check(err_cnt_o == 4'd0, "R10 count zero after reset", err_cnt_o, 0);
        check(err_flag_o == 1'b0, "R11 flag low after reset", err_flag_o, 0);
    endtask

    task automatic t_sequence();
        int errs = 0;
        tx_ready_i = 1'b1;
        pulse_start();
        for (int i = 0; i < 402; i++) begin
            if (!tx_valid_o || tx_data_o != gen_byte(i)) begin
                errs++;
                check(1'b0, "R1 generated byte", tx_data_o, gen_byte(i));
            end
            @(negedge clk);
        end
        check(errs == 0, "R1 two full blocks", errs, 0);
    endtask

    task automatic t_stall();
        logic [7:0] held;
        tx_ready_i = 1'b1;
        pulse_start();
        repeat (10) @(negedge clk);
        tx_ready_i = 1'b0;
        held = tx_data_o;
        check(held == gen_byte(10), "R2 byte at stall", held, gen_byte(10));
        repeat (5) begin
            @(negedge clk);
            check(tx_valid_o && tx_data_o == held, "R2 held under stall", tx_data_o, held);
        end
        tx_ready_i = 1'b1;
        @(negedge clk);
        check(tx_data_o == gen_byte(11), "R2 resumes with next byte", tx_data_o, gen_byte(11));
    endtask

    task automatic t_loopback();
        int reps = 0;
        int dirty = 0;
        tx_ready_i = 1'b0;
        loop_sel = 1'b1;
        pulse_start();
        tx_ready_i = 1'b1;
        for (int i = 0; i < 3 * 201 + 4; i++) begin
            @(negedge clk);
            if (rep_valid_o) begin
                reps++;
                if (rep_class_o != 3'd0 || rep_mism_o != 8'd0 || rep_last_o != 8'd0) dirty++;
            end
        end
        check(reps == 2, "R5 R9 clean loop report count", reps, 2);
        check(dirty == 0, "R1 R9 clean loop reports", dirty, 0);
        check(err_cnt_o == 4'd0, "R10 no errors in loop", err_cnt_o, 0);
        tx_ready_i = 1'b0;
        loop_sel = 1'b0;
    endtask

    task automatic t_hunt();
        pulse_start();
        check(err_cnt_o == 4'd0 && !err_flag_o, "R3 start clears count", err_cnt_o, 0);
        send_byte(8'h00); send_byte(8'h55); send_byte(8'h2E);
        check(!rep_valid_o, "R5 no report while hunting", rep_valid_o, 0);
        send_byte(8'hFE);   // low six bits equal marker
        check(!rep_valid_o, "R5 first marker only locks", rep_valid_o, 0);
        send_block(200, -1, -1, -1, 8'h3E);
        check(rep_valid_o, "R4 upper-bit marker locked checker", rep_valid_o, 1);
        check(rep_class_o == 3'd0, "R5 hunt bytes left no error", rep_class_o, 0);
        check(rep_mism_o == 8'd0, "R5 hunt bytes no mismatch", rep_mism_o, 0);
        check(rep_last_o == 8'd0, "R9 last expected on full block", rep_last_o, 0);
        idle();
        check(err_cnt_o == 4'd0, "R10 clean block not counted", err_cnt_o, 0);
    endtask

    task automatic t_mismatch();
        send_block(200, 5, 77, 30, 8'h7E);
        check(rep_valid_o, "R9 report after marker", rep_valid_o, 1);
        check(rep_class_o == 3'b001, "R6 class mismatch only", rep_class_o, 1);
        check(rep_mism_o == 8'd2, "R6 mismatch count ignores bit4", rep_mism_o, 2);
        idle();
        check(err_cnt_o == 4'd1, "R10 count after errored block", err_cnt_o, 1);
        check(err_flag_o, "R11 flag set", err_flag_o, 1);
    endtask

    task automatic t_short();
        send_block(150, -1, -1, -1, 8'h3E);
        check(rep_class_o == 3'b100, "R8 short block class", rep_class_o, 4);
        check(rep_last_o == 8'd50, "R9 last expected short", rep_last_o, 50);
        check(rep_mism_o == 8'd0, "R9 mismatch cleared after report", rep_mism_o, 0);
        idle();
        check(err_cnt_o == 4'd2, "R10 count two", err_cnt_o, 2);
    endtask

    task automatic t_overlong();
        send_block(203, -1, -1, -1, 8'h3E);
        check(rep_class_o == 3'b110, "R7 overlong plus length class", rep_class_o, 6);
        check(rep_mism_o == 8'd0, "R7 overlong bytes not compared", rep_mism_o, 0);
        check(rep_last_o == 8'd0, "R7 last expected zero", rep_last_o, 0);
        send_block(200, -1, -1, -1, 8'h3E);
        check(rep_class_o == 3'd0, "R9 errors cleared for next block", rep_class_o, 0);
        idle();
        check(err_cnt_o == 4'd3, "R10 count three", err_cnt_o, 3);
    endtask

    task automatic t_saturate();
        repeat (14) send_byte(8'h3E);   // each one-byte block has bad length
        idle();
        check(err_cnt_o == 4'd15, "R10 count saturates", err_cnt_o, 15);
        send_byte(8'h3E); idle();
        check(err_cnt_o == 4'd15, "R10 no wrap", err_cnt_o, 15);
        check(err_flag_o, "R11 flag held", err_flag_o, 1);
        pulse_start();
        check(err_cnt_o == 4'd0, "R3 start clears count", err_cnt_o, 0);
        check(err_flag_o == 1'b0, "R11 start clears flag", err_flag_o, 0);
        send_byte(8'h11); send_byte(8'h3E);
        check(!rep_valid_o, "R3 checker hunts after start", rep_valid_o, 0);
        idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sequence();
        t_stall();
        t_loopback();
        t_hunt();
        t_mismatch();
        t_short();
        t_overlong();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule